// File: doc/BRIEF.md
# Boundary-Scan Test Access Port for Peripheral Pins

This block is a serial test access port that places a boundary-scan register between the core logic and the pads of a small peripheral pin group. The group has a parameterised number of general-purpose pins, one serial-port receive input, one serial-port transmit output and two open-drain bus pins (data and clock). Each bidirectional pin has three scan cells: input, output and output enable. The receive pin has one input cell. The transmit pin has one output cell.

A tester drives the port from the test clock, mode select and data input, and reads the serial data output. A 4-bit instruction selects the active data register: the boundary register, a 32-bit identification register, or a 1-bit bypass register. Under the external-test instruction the pins are taken away from the core. Pad outputs and enables then come from update latches, and the core's inputs come from the latched input cells. Under the sample/preload instruction the functional path stays intact. A scan then only records live values and loads the latches for later use.

Top module: `jtag_bs_top`

## Requirements
- R1: The controller is the standard 16-state test-port machine advanced on rising `tck`. `trstN` low forces Test-Logic-Reset at once. Five rising edges with `tms` high reach Test-Logic-Reset from any state.
- R2: The instruction register is 4 bits wide and is shifted LSB first from `tdi`. Capture-IR loads binary 0001. A new instruction takes effect on the falling `tck` in Update-IR. Test-Logic-Reset loads code 1.
- R3: Code 1 selects a 32-bit identification register that captures 0x000018FF and shifts it out LSB first.
- R4: Any code other than 0, 1 or 2 selects a 1-bit bypass register. It captures 0, so the data on `tdo` lags `tdi` by one bit.
- R5: The boundary register has 3*N_GPIO+8 cells, and its bit 0 is shifted out first. For general-purpose pin g, cells 3g, 3g+1 and 3g+2 are input, output and enable. The receive input is cell 3*N_GPIO and the transmit output is cell 3*N_GPIO+1. Open-drain pin k (0 data, 1 clock) uses cells 3*N_GPIO+2+3k, +1 and +2 for input, output and enable.
- R6: Code 2 (sample/preload) leaves pads and core connected. Capture-DR records pad inputs and core outputs and enables. Update-DR loads the latches and has no effect on any pin.
- R7: Code 0 (external test) drives pad outputs and enables, and the core-side inputs, from the update latches. Capture-DR takes input cells from the pads and output and enable cells from the latches.
- R8: Update latches change only on the falling `tck` in Update-DR while the boundary register is selected. Pins driven from them stay still during Shift-DR.
- R9: Test-Logic-Reset clears the boundary shift register and the update latches.
- R10: `tdo` is registered on falling `tck`. In Shift-IR and Shift-DR it carries the LSB of the selected register. In every other state it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| gpioCoreOut | input | N_GPIO | Core output values for general-purpose pins |
| gpioCoreOe | input | N_GPIO | Core output enables for general-purpose pins |
| gpioCoreIn | output | N_GPIO | Input values delivered to the core |
| gpioPadIn | input | N_GPIO | Values seen at the general-purpose pads |
| gpioPadOut | output | N_GPIO | Output values driven to the pads |
| gpioPadOe | output | N_GPIO | Output enables driven to the pads |
| uartRxPad | input | 1 | Serial receive pad value |
| uartRxCore | output | 1 | Serial receive value delivered to the core |
| uartTxCore | input | 1 | Serial transmit value from the core |
| uartTxPad | output | 1 | Serial transmit value driven to the pad |
| i2cCoreOut | input | 2 | Core output values for data (0) and clock (1) |
| i2cCoreOe | input | 2 | Core output enables for data and clock |
| i2cCoreIn | output | 2 | Data and clock values delivered to the core |
| i2cPadIn | input | 2 | Values seen at the data and clock pads |
| i2cPadOut | output | 2 | Data and clock output values to the pads |
| i2cPadOe | output | 2 | Data and clock output enables to the pads |

## Verification
The assertions check four things on every cycle:
- the reset instruction is held while the controller sits in Test-Logic-Reset;
- the only exit from that state goes to Run-Test/Idle;
- the update latches move only in Update-DR or reset, and under external test the pad outputs stay still through Shift-DR;
- `tdo` stays low outside the shift states.

Only the bench scenarios can show the rest:
- the cell ordering and the capture contents under both boundary instructions;
- the identification value and the one-bit bypass lag;
- that `tdo` changes only on the falling edge;
- that a controller reset wipes earlier preload data, whether it comes from the five-high sequence or the asynchronous pin.

// File: rtl/jtag_bs_pkg.sv
package jtag_bs_pkg;

  typedef enum logic [3:0] {
    TAP_RESET  = 4'h0,
    RUN_IDLE   = 4'h1,
    SEL_DR     = 4'h2,
    CAP_DR     = 4'h3,
    SHF_DR     = 4'h4,
    EX1_DR     = 4'h5,
    PAU_DR     = 4'h6,
    EX2_DR     = 4'h7,
    UPD_DR     = 4'h8,
    SEL_IR     = 4'h9,
    CAP_IR     = 4'hA,
    SHF_IR     = 4'hB,
    EX1_IR     = 4'hC,
    PAU_IR     = 4'hD,
    EX2_IR     = 4'hE,
    UPD_IR     = 4'hF
  } tapState_e;

  // instruction codes
  localparam int CODE_EXTEST = 0;
  localparam int CODE_IDENT  = 1;
  localparam int CODE_SAMPLE = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic inReset;
    logic capDr;
    logic shfDr;
    logic updDr;
    logic shfIr;
    logic selBound;
    logic selIdent;
    logic extest;
  } tapStrobe_t;

endpackage

// File: rtl/jtag_bs_ctrl.sv
module jtag_bs_ctrl
  import jtag_bs_pkg::*;
#(
  parameter int IR_W = 4
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tms,
  input  logic            tdi,
  output tapState_e       state,
  output logic [IR_W-1:0] irReg,
  output logic            irTdoBit,
  output tapStrobe_t      strobe
);

  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-2){1'b0}}, 2'b01};
  localparam logic [IR_W-1:0] IR_AT_RESET = IR_W'(CODE_IDENT);

  tapState_e       nextState;
  logic [IR_W-1:0] irShift;

  // next state of the test-port machine
  always_comb begin
    nextState = state;
    unique case (state)
      TAP_RESET: nextState = tms ? TAP_RESET : RUN_IDLE;
      RUN_IDLE:  nextState = tms ? SEL_DR    : RUN_IDLE;
      SEL_DR:    nextState = tms ? SEL_IR    : CAP_DR;
      CAP_DR:    nextState = tms ? EX1_DR    : SHF_DR;
      SHF_DR:    nextState = tms ? EX1_DR    : SHF_DR;
      EX1_DR:    nextState = tms ? UPD_DR    : PAU_DR;
      PAU_DR:    nextState = tms ? EX2_DR    : PAU_DR;
      EX2_DR:    nextState = tms ? UPD_DR    : SHF_DR;
      UPD_DR:    nextState = tms ? SEL_DR    : RUN_IDLE;
      SEL_IR:    nextState = tms ? TAP_RESET : CAP_IR;
      CAP_IR:    nextState = tms ? EX1_IR    : SHF_IR;
      SHF_IR:    nextState = tms ? EX1_IR    : SHF_IR;
      EX1_IR:    nextState = tms ? UPD_IR    : PAU_IR;
      PAU_IR:    nextState = tms ? EX2_IR    : PAU_IR;
      EX2_IR:    nextState = tms ? UPD_IR    : SHF_IR;
      UPD_IR:    nextState = tms ? SEL_DR    : RUN_IDLE;
      default:   nextState = TAP_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= TAP_RESET;
    else        state <= nextState;
  end

  // instruction shift stage, rising edge
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= '0;
    end else begin
      unique case (state)
        TAP_RESET: irShift <= '0;
        CAP_IR:    irShift <= IR_CAPTURE;
        SHF_IR:    irShift <= {tdi, irShift[IR_W-1:1]};
        default:   irShift <= irShift;
      endcase
    end
  end

  // active instruction, falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)                  irReg <= IR_AT_RESET;
    else if (state == TAP_RESET) irReg <= IR_AT_RESET;
    else if (state == UPD_IR)    irReg <= irShift;
  end

  assign irTdoBit = irShift[0];

  always_comb begin
    strobe.inReset  = (state == TAP_RESET);
    strobe.capDr    = (state == CAP_DR);
    strobe.shfDr    = (state == SHF_DR);
    strobe.updDr    = (state == UPD_DR);
    strobe.shfIr    = (state == SHF_IR);
    strobe.extest   = (irReg == IR_W'(CODE_EXTEST));
    strobe.selBound = strobe.extest || (irReg == IR_W'(CODE_SAMPLE));
    strobe.selIdent = (irReg == IR_W'(CODE_IDENT));
  end

endmodule

// File: rtl/jtag_bs_data.sv
module jtag_bs_data
  import jtag_bs_pkg::*;
#(
  parameter int          N_GPIO   = 4,
  parameter int          N_I2C    = 2,
  parameter logic [31:0] ID_VALUE = 32'h000018FF
) (
  input  logic                            tck,
  input  logic                            trstN,
  input  logic                            tdi,
  input  tapStrobe_t                      strobe,
  input  logic                            irTdoBit,
  output logic                            tdo,
  output logic [3*N_GPIO+3*N_I2C+1:0]     updVec,
  input  logic [N_GPIO-1:0]               gpioCoreOut,
  input  logic [N_GPIO-1:0]               gpioCoreOe,
  output logic [N_GPIO-1:0]               gpioCoreIn,
  input  logic [N_GPIO-1:0]               gpioPadIn,
  output logic [N_GPIO-1:0]               gpioPadOut,
  output logic [N_GPIO-1:0]               gpioPadOe,
  input  logic                            uartRxPad,
  output logic                            uartRxCore,
  input  logic                            uartTxCore,
  output logic                            uartTxPad,
  input  logic [N_I2C-1:0]                i2cCoreOut,
  input  logic [N_I2C-1:0]                i2cCoreOe,
  output logic [N_I2C-1:0]                i2cCoreIn,
  input  logic [N_I2C-1:0]                i2cPadIn,
  output logic [N_I2C-1:0]                i2cPadOut,
  output logic [N_I2C-1:0]                i2cPadOe
);

  localparam int CELLS    = 3*N_GPIO + 3*N_I2C + 2;
  localparam int RX_CELL  = 3*N_GPIO;
  localparam int TX_CELL  = RX_CELL + 1;
  localparam int I2C_BASE = RX_CELL + 2;
  localparam int ID_W     = 32;

  logic [CELLS-1:0] capVec;
  logic [CELLS-1:0] bsShift;
  logic [ID_W-1:0]  idShift;
  logic             bypassBit;
  logic             drTdoBit;

  // three cells per bidirectional general-purpose pin
  for (genvar g = 0; g < N_GPIO; g++) begin : g_gpio
    localparam int B = 3*g;
    assign capVec[B]   = gpioPadIn[g];
    assign capVec[B+1] = strobe.extest ? updVec[B+1] : gpioCoreOut[g];
    assign capVec[B+2] = strobe.extest ? updVec[B+2] : gpioCoreOe[g];
    assign gpioCoreIn[g] = strobe.extest ? updVec[B]   : gpioPadIn[g];
    assign gpioPadOut[g] = strobe.extest ? updVec[B+1] : gpioCoreOut[g];
    assign gpioPadOe[g]  = strobe.extest ? updVec[B+2] : gpioCoreOe[g];
  end

  // single input cell and single output cell for the serial port
  assign capVec[RX_CELL] = uartRxPad;
  assign capVec[TX_CELL] = strobe.extest ? updVec[TX_CELL] : uartTxCore;
  assign uartRxCore      = strobe.extest ? updVec[RX_CELL] : uartRxPad;
  assign uartTxPad       = strobe.extest ? updVec[TX_CELL] : uartTxCore;

  // three cells per open-drain bus pin
  for (genvar k = 0; k < N_I2C; k++) begin : g_i2c
    localparam int B = I2C_BASE + 3*k;
    assign capVec[B]   = i2cPadIn[k];
    assign capVec[B+1] = strobe.extest ? updVec[B+1] : i2cCoreOut[k];
    assign capVec[B+2] = strobe.extest ? updVec[B+2] : i2cCoreOe[k];
    assign i2cCoreIn[k] = strobe.extest ? updVec[B]   : i2cPadIn[k];
    assign i2cPadOut[k] = strobe.extest ? updVec[B+1] : i2cCoreOut[k];
    assign i2cPadOe[k]  = strobe.extest ? updVec[B+2] : i2cCoreOe[k];
  end

  // boundary shift stage
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bsShift <= '0;
    end else if (strobe.inReset) begin
      bsShift <= '0;
    end else if (strobe.selBound) begin
      if (strobe.capDr)      bsShift <= capVec;
      else if (strobe.shfDr) bsShift <= {tdi, bsShift[CELLS-1:1]};
    end
  end

  // update latches, falling edge only
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)                                updVec <= '0;
    else if (strobe.inReset)                   updVec <= '0;
    else if (strobe.updDr && strobe.selBound)  updVec <= bsShift;
  end

  // identification register
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      idShift <= '0;
    end else if (strobe.selIdent) begin
      if (strobe.capDr)      idShift <= ID_VALUE;
      else if (strobe.shfDr) idShift <= {tdi, idShift[ID_W-1:1]};
    end
  end

  // bypass bit
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bypassBit <= 1'b0;
    end else if (!strobe.selBound && !strobe.selIdent) begin
      if (strobe.capDr)      bypassBit <= 1'b0;
      else if (strobe.shfDr) bypassBit <= tdi;
    end
  end

  always_comb begin
    if (strobe.selBound)      drTdoBit = bsShift[0];
    else if (strobe.selIdent) drTdoBit = idShift[0];
    else                      drTdoBit = bypassBit;
  end

  // serial output, falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)            tdo <= 1'b0;
    else if (strobe.shfIr) tdo <= irTdoBit;
    else if (strobe.shfDr) tdo <= drTdoBit;
    else                   tdo <= 1'b0;
  end

endmodule

// File: rtl/jtag_bs_top.sv
module jtag_bs_top
  import jtag_bs_pkg::*;
#(
  parameter int          N_GPIO   = 4,
  parameter int          IR_W     = 4,
  parameter logic [31:0] ID_VALUE = 32'h000018FF
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  input  logic [N_GPIO-1:0] gpioCoreOut,
  input  logic [N_GPIO-1:0] gpioCoreOe,
  output logic [N_GPIO-1:0] gpioCoreIn,
  input  logic [N_GPIO-1:0] gpioPadIn,
  output logic [N_GPIO-1:0] gpioPadOut,
  output logic [N_GPIO-1:0] gpioPadOe,
  input  logic              uartRxPad,
  output logic              uartRxCore,
  input  logic              uartTxCore,
  output logic              uartTxPad,
  input  logic [1:0]        i2cCoreOut,
  input  logic [1:0]        i2cCoreOe,
  output logic [1:0]        i2cCoreIn,
  input  logic [1:0]        i2cPadIn,
  output logic [1:0]        i2cPadOut,
  output logic [1:0]        i2cPadOe
);

  localparam int N_I2C = 2;
  localparam int CELLS = 3*N_GPIO + 3*N_I2C + 2;

  tapState_e        tapState;
  logic [IR_W-1:0]  irReg;
  logic             irTdoBit;
  tapStrobe_t       strobe;
  logic [CELLS-1:0] updVec;

  jtag_bs_ctrl #(.IR_W(IR_W)) uCtrl (
    .tck      (tck),
    .trstN    (trstN),
    .tms      (tms),
    .tdi      (tdi),
    .state    (tapState),
    .irReg    (irReg),
    .irTdoBit (irTdoBit),
    .strobe   (strobe)
  );

  jtag_bs_data #(.N_GPIO(N_GPIO), .N_I2C(N_I2C), .ID_VALUE(ID_VALUE)) uData (
    .tck         (tck),
    .trstN       (trstN),
    .tdi         (tdi),
    .strobe      (strobe),
    .irTdoBit    (irTdoBit),
    .tdo         (tdo),
    .updVec      (updVec),
    .gpioCoreOut (gpioCoreOut),
    .gpioCoreOe  (gpioCoreOe),
    .gpioCoreIn  (gpioCoreIn),
    .gpioPadIn   (gpioPadIn),
    .gpioPadOut  (gpioPadOut),
    .gpioPadOe   (gpioPadOe),
    .uartRxPad   (uartRxPad),
    .uartRxCore  (uartRxCore),
    .uartTxCore  (uartTxCore),
    .uartTxPad   (uartTxPad),
    .i2cCoreOut  (i2cCoreOut),
    .i2cCoreOe   (i2cCoreOe),
    .i2cCoreIn   (i2cCoreIn),
    .i2cPadIn    (i2cPadIn),
    .i2cPadOut   (i2cPadOut),
    .i2cPadOe    (i2cPadOe)
  );

endmodule

// File: rtl/jtag_bs_chk.sv
module jtag_bs_chk
  import jtag_bs_pkg::*;
#(
  parameter int N_GPIO = 4,
  parameter int IR_W   = 4,
  parameter int CELLS  = 3*N_GPIO + 8
) (
  input logic              tck,
  input logic              trstN,
  input logic              tdo,
  input tapState_e         state,
  input logic [IR_W-1:0]   irReg,
  input logic [CELLS-1:0]  updVec,
  input logic [N_GPIO-1:0] gpioPadOut,
  input logic [N_GPIO-1:0] gpioPadOe
);

  // R1: reset state only exits to Run-Test/Idle
  p_reset_exit_r1: assert property (@(posedge tck) disable iff (!trstN)
    (state == TAP_RESET) |=> (state == TAP_RESET || state == RUN_IDLE));

  // R2: reset state holds the identification instruction
  p_reset_ident_r2: assert property (@(posedge tck) disable iff (!trstN)
    (state == TAP_RESET) |-> (irReg == IR_W'(CODE_IDENT)));

  // R8: latches move only during Update-DR or reset
  p_latch_window_r8: assert property (@(posedge tck) disable iff (!trstN)
    !$stable(updVec) |-> (state == UPD_DR || state == TAP_RESET));

  // R8: pads frozen while shifting under external test
  p_pads_frozen_r8: assert property (@(posedge tck) disable iff (!trstN)
    (state == SHF_DR && irReg == IR_W'(CODE_EXTEST)) |-> ($stable(gpioPadOut) && $stable(gpioPadOe)));

  // R10: serial output quiet outside shift states
  p_tdo_quiet_r10: assert property (@(posedge tck) disable iff (!trstN)
    !(state == SHF_DR || state == SHF_IR) |-> (tdo == 1'b0));

endmodule

bind jtag_bs_top jtag_bs_chk #(.N_GPIO(N_GPIO), .IR_W(IR_W), .CELLS(CELLS)) uChk (
  .tck        (tck),
  .trstN      (trstN),
  .tdo        (tdo),
  .state      (tapState),
  .irReg      (irReg),
  .updVec     (updVec),
  .gpioPadOut (gpioPadOut),
  .gpioPadOe  (gpioPadOe)
);

// File: tb/jtag_bs_top_test.sv
module jtag_bs_top_test;
  localparam int G     = 4;
  localparam int CELLS = 3*G + 8;
  localparam int PINS  = 3*G + 8;

  logic tck = 1'b0, trstN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo;
  logic [G-1:0] gpioCoreOut = '0, gpioCoreOe = '0, gpioPadIn = '0;
  logic [G-1:0] gpioCoreIn, gpioPadOut, gpioPadOe;
  logic uartRxPad = 1'b0, uartTxCore = 1'b0;
  logic uartRxCore, uartTxPad;
  logic [1:0] i2cCoreOut = '0, i2cCoreOe = '0, i2cPadIn = '0;
  logic [1:0] i2cCoreIn, i2cPadOut, i2cPadOe;

  int nChecks = 0, nFails = 0;
  bit shiftMoved = 1'b0;

  always #4 tck = ~tck;

  jtag_bs_top #(.N_GPIO(G)) uut (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo),
    .gpioCoreOut(gpioCoreOut), .gpioCoreOe(gpioCoreOe), .gpioCoreIn(gpioCoreIn),
    .gpioPadIn(gpioPadIn), .gpioPadOut(gpioPadOut), .gpioPadOe(gpioPadOe),
    .uartRxPad(uartRxPad), .uartRxCore(uartRxCore), .uartTxCore(uartTxCore), .uartTxPad(uartTxPad),
    .i2cCoreOut(i2cCoreOut), .i2cCoreOe(i2cCoreOe), .i2cCoreIn(i2cCoreIn),
    .i2cPadIn(i2cPadIn), .i2cPadOut(i2cPadOut), .i2cPadOe(i2cPadOe)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [PINS-1:0] obsPins();
    return {i2cCoreIn, i2cPadOe, i2cPadOut, uartTxPad, uartRxCore, gpioCoreIn, gpioPadOe, gpioPadOut};
  endfunction

  function automatic logic [PINS-1:0] passPins();
    return {i2cPadIn, i2cCoreOe, i2cCoreOut, uartTxCore, uartRxPad, gpioPadIn, gpioCoreOe, gpioCoreOut};
  endfunction

  function automatic logic [PINS-1:0] extPins(logic [CELLS-1:0] lat);
    logic [G-1:0] po, pe, ci;
    logic [1:0] qo, qe, qi;
    for (int g = 0; g < G; g++) begin
      ci[g] = lat[3*g]; po[g] = lat[3*g+1]; pe[g] = lat[3*g+2];
    end
    for (int k = 0; k < 2; k++) begin
      qi[k] = lat[3*G+2+3*k]; qo[k] = lat[3*G+3+3*k]; qe[k] = lat[3*G+4+3*k];
    end
    return {qi, qe, qo, lat[3*G+1], lat[3*G], ci, pe, po};
  endfunction

  function automatic logic [CELLS-1:0] liveVec();
    logic [CELLS-1:0] v;
    for (int g = 0; g < G; g++) begin
      v[3*g] = gpioPadIn[g]; v[3*g+1] = gpioCoreOut[g]; v[3*g+2] = gpioCoreOe[g];
    end
    v[3*G] = uartRxPad; v[3*G+1] = uartTxCore;
    for (int k = 0; k < 2; k++) begin
      v[3*G+2+3*k] = i2cPadIn[k]; v[3*G+3+3*k] = i2cCoreOut[k]; v[3*G+4+3*k] = i2cCoreOe[k];
    end
    return v;
  endfunction

  function automatic logic [CELLS-1:0] extCap(logic [CELLS-1:0] lat);
    logic [CELLS-1:0] v;
    v = liveVec();
    for (int g = 0; g < G; g++) begin
      v[3*g+1] = lat[3*g+1]; v[3*g+2] = lat[3*g+2];
    end
    v[3*G+1] = lat[3*G+1];
    for (int k = 0; k < 2; k++) begin
      v[3*G+3+3*k] = lat[3*G+3+3*k]; v[3*G+4+3*k] = lat[3*G+4+3*k];
    end
    return v;
  endfunction

  task automatic applyPattern(logic [31:0] v);
    gpioPadIn = v[3:0]; gpioCoreOut = v[7:4]; gpioCoreOe = v[11:8];
    uartRxPad = v[12]; uartTxCore = v[13];
    i2cPadIn = v[15:14]; i2cCoreOut = v[17:16]; i2cCoreOe = v[19:18];
  endtask

  // one controller step; returns just after the falling edge
  task automatic tick(logic m, logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic tapReset();
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  task automatic irScan(logic [3:0] code, output logic [3:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) begin
      cap[i] = tdo;
      tick(i == 3, code[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic drScan(logic [63:0] din, int n, output logic [63:0] dout);
    logic [PINS-1:0] ref0;
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    ref0 = obsPins();
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      if (obsPins() !== ref0) shiftMoved = 1'b1;
      tick(i == n-1, din[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  initial begin : watchdog
    #(8*100000);
    nFails++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [3:0]  irCap;
    logic [63:0] dout;
    logic [CELLS-1:0] lat, din;

    applyPattern(32'h000A5C3);
    #20;
    @(negedge tck); #1;
    trstN = 1'b1;
    // reset state: pins pass through, serial output low
    check("R1 reset passthrough", obsPins(), passPins());
    check("R10 tdo at reset", tdo, 0);
    tick(0, 0);

    // R2/R3: default instruction is identification
    drScan(64'h0, 32, dout);
    check("R3 idcode value", dout, 64'h000018FF);
    check("R10 tdo idle", tdo, 0);

    // R2: capture pattern, R4: bypass lag
    irScan(4'hF, irCap);
    check("R2 ir capture", irCap, 4'b0001);
    drScan(64'hA5, 8, dout);
    check("R4 bypass lag", dout, 64'h4A);

    // R10: tdo moves on the falling edge only
    tick(1, 0); tick(0, 0); tick(0, 0);
    check("R10 bypass first bit", tdo, 0);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    check("R10 held over rising edge", tdo, 0);
    @(negedge tck); #1;
    check("R10 after falling edge", tdo, 1);
    tick(1, 0); tick(1, 0); tick(0, 0);

    irScan(4'h7, irCap);
    drScan(64'h3C, 8, dout);
    check("R4 bypass code 7", dout, 64'h78);

    // R5/R6: sample sweep, pins untouched
    irScan(4'h2, irCap);
    lat = '0;
    for (int p = 0; p < 24; p++) begin
      logic [31:0] v;
      v = (p * 32'h0009E377) ^ (32'h000F0F0F >> (p % 5));
      applyPattern(v);
      din = CELLS'((v * 32'd13) ^ 32'h5A5A5);
      drScan(64'(din), CELLS, dout);
      check("R5 R6 sample capture", dout, 64'(liveVec()));
      check("R6 pins untouched", obsPins(), passPins());
      lat = din;
    end
    check("R8 no motion while shifting", shiftMoved, 0);

    // R7: preloaded latches appear when external test selected
    irScan(4'h0, irCap);
    check("R7 preload drives pins", obsPins(), extPins(lat));
    for (int p = 0; p < 10; p++) begin
      logic [31:0] v;
      v = (p * 32'h00031F2B) ^ 32'h000C3A5;
      applyPattern(v);
      check("R7 core isolated", obsPins(), extPins(lat));
      din = CELLS'((v * 32'd7) ^ (32'hFFFFF >> p));
      drScan(64'(din), CELLS, dout);
      check("R7 extest capture", dout, 64'(extCap(lat)));
      check("R8 update applied", obsPins(), extPins(din));
      lat = din;
    end
    check("R8 pads still during shift", shiftMoved, 0);

    // R1/R9: five high TMS from Shift-DR, latches cleared
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) tick(1, 1);
    check("R1 five tms to reset", obsPins(), passPins());
    tick(0, 0);
    irScan(4'h0, irCap);
    check("R9 latches cleared", obsPins(), extPins('0));
    drScan(64'h0, CELLS, dout);
    check("R9 capture after clear", dout, 64'(extCap('0)));

    // R1: asynchronous reset mid-operation
    irScan(4'h2, irCap);
    drScan(64'hFFFFF, CELLS, dout);
    irScan(4'h0, irCap);
    check("R7 all-ones preload", obsPins(), extPins('1));
    #1 trstN = 1'b0;
    #1;
    check("R1 async reset passthrough", obsPins(), passPins());
    trstN = 1'b1;
    @(negedge tck); #1;
    tick(0, 0);
    irScan(4'h0, irCap);
    check("R9 async clears latches", obsPins(), extPins('0));

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule